// File: doc/BRIEF.md
# Eight-Channel DMA Request Arbiter

This block decides which of eight DMA channels may use the bus next. Each channel supplies its own enable bit, a two-bit request-source code and a bus-mode bit. A set of global inputs gates every channel at once: a master enable, a non-maskable-interrupt flag and an address-error flag. A mode input switches between normal operation and an alternate operating mode, where a channel-count bit selects four or eight usable channels. The block also keeps a transfer counter and a transfer-end flag for each channel. It combines all of these with the incoming auto, external and peripheral requests and issues at most one grant at a time, by fixed priority.

The bus side reports each finished transfer with a one-cycle done pulse. A channel in burst mode keeps the grant until its counter runs out. A channel in cycle-steal mode gives the grant back after every transfer and competes again. Address generation, the data path and the bus protocol sit outside this block.

Top module: `dma_arb`

## Requirements
- R1: A channel is granted only if its enable is 1, the master enable is 1, its end flag is 0, the NMI flag is 0 and the address-error flag is 0. Enabling the master alone grants nothing.
- R2: If the master enable falls while a grant is held, the grant drops at the next clock edge. The counter of the suspended channel keeps its value, and the channel resumes when the master enable returns.
- R3: At most one channel is granted. The lowest-numbered eligible channel wins (channel 0 highest, channel 7 lowest). `grantVec` is the one-hot form of `grantId`.
- R4: Each channel's source code is the field `srcSel[2i+1:2i]`. Code 0 is auto, which requests continuously while the channel is enabled. Code 1 is external (`extReq[i]`). Code 2 is peripheral (`periphReq[i]`). Code 3 never requests.
- R5: In normal mode (`altMode`=0) all eight channels can be granted, but an external request counts only on channels 0 and 1.
- R6: In the alternate mode, `chCount8`=0 makes only channels 0 to 3 usable, whatever their source, and accepts external requests on those four. `chCount8`=1 makes all eight usable and accepts external requests on channels 0 to 7.
- R7: A burst-mode channel keeps the grant across done pulses until its counter reaches zero. On the done pulse that empties the counter, its end flag sets and the grant drops at the same edge.
- R8: A cycle-steal channel (`burstMode[i]`=0) drops the grant on the edge of every done pulse. Arbitration runs again on the following edge.
- R9: A load pulse on `cntLoad[i]` writes `loadVal` into channel i's counter and clears its end flag. Loading zero sets the end flag instead.
- R10: If the NMI flag or the address-error flag goes high while a grant is held, the grant drops at the next edge. No grant is issued while either flag is high.
- R11: After reset no grant is held and every end flag reads 1.
- R12: A grant is registered. A request that becomes eligible is granted at the next clock edge, and a grant that loses its eligibility drops at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterEn | input | 1 | Global master enable |
| nmiFlag | input | 1 | Non-maskable-interrupt flag, blocks all channels |
| addrErrFlag | input | 1 | Address-error flag, blocks all channels |
| altMode | input | 1 | 1 selects the alternate operating mode |
| chCount8 | input | 1 | Alternate mode: 0 gives four channels, 1 gives eight |
| chEnable | input | 8 | Per-channel enable |
| srcSel | input | 16 | Two-bit request-source code per channel |
| burstMode | input | 8 | Per-channel bus mode, 1 burst, 0 cycle steal |
| extReq | input | 8 | External request levels |
| periphReq | input | 8 | On-chip peripheral request levels |
| cntLoad | input | 8 | Per-channel counter load strobe |
| loadVal | input | 16 | Value written by a load strobe |
| xferDone | input | 1 | One transfer of the granted channel finished |
| grantValid | output | 1 | A grant is held |
| grantId | output | 3 | Index of the granted channel |
| grantVec | output | 8 | One-hot grant |
| endFlags | output | 8 | Per-channel transfer-end flags |

## Verification
Several channels request at once with only the enable, source code or mode varied between runs. A wrong grant therefore points at one gating term: priority, source decode, external-acceptance window or channel-count limit. The burst and cycle-steal runs use the same counter length and pulse sequence. They can only be told apart by whether the grant survives a done pulse and whether an idle cycle appears before the re-grant. The suspend and fault runs resume a partly finished burst and count the remaining pulses to its end. This shows that the counter kept its value across the interruption.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned NUM_CH = 8;
  localparam int unsigned ID_W   = $clog2(NUM_CH);

  typedef enum logic [1:0] {
    SRC_AUTO   = 2'd0,
    SRC_EXT    = 2'd1,
    SRC_PERIPH = 2'd2,
    SRC_OFF    = 2'd3
  } srcKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic            decValid;
    logic [ID_W-1:0] decIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/dma_arb_dp.sv
module dma_arb_dp
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH   = NUM_CH,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH-1:0]   cntLoad,
  input  logic [CNT_W-1:0] loadVal,
  input  ctrlStrobe_t      strobe,
  output logic [NCH-1:0]   endFlags,
  output logic [NCH-1:0]   lastXfer
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic loadZero;
  assign loadZero = (loadVal == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic             hit;

    assign hit         = strobe.decValid && (strobe.decIdx == ID_W'(i));
    assign lastXfer[i] = (cnt == ONE);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt         <= '0;
        endFlags[i] <= 1'b1;
      end else if (cntLoad[i]) begin
        cnt         <= loadVal;
        endFlags[i] <= loadZero;
      end else if (hit) begin
        cnt <= cnt - ONE;
        if (cnt == ONE) endFlags[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterEn,
  input  logic             nmiFlag,
  input  logic             addrErrFlag,
  input  logic             altMode,
  input  logic             chCount8,
  input  logic [NCH-1:0]   chEnable,
  input  logic [2*NCH-1:0] srcSel,
  input  logic [NCH-1:0]   burstMode,
  input  logic [NCH-1:0]   extReq,
  input  logic [NCH-1:0]   periphReq,
  input  logic [NCH-1:0]   endFlags,
  input  logic [NCH-1:0]   lastXfer,
  input  logic             xferDone,
  output logic             grantValid,
  output logic [ID_W-1:0]  grantId,
  output logic [NCH-1:0]   grantVec,
  output ctrlStrobe_t      strobe
);
  localparam int unsigned HALF    = NCH / 2;
  localparam int unsigned EXT_STD = 2;

  logic           globalOk;
  logic [NCH-1:0] chPresent, extOk, reqRaw, eligible;

  assign globalOk = masterEn && !nmiFlag && !addrErrFlag;

  for (genvar i = 0; i < NCH; i++) begin : g_gate
    localparam bit LOWER_HALF = (i < HALF);
    localparam bit STD_EXT    = (i < EXT_STD);
    srcKind_e kind;

    assign kind         = srcKind_e'(srcSel[2*i +: 2]);
    assign chPresent[i] = !altMode || chCount8 || LOWER_HALF;
    assign extOk[i]     = altMode ? chPresent[i] : STD_EXT;

    always_comb begin
      case (kind)
        SRC_AUTO:   reqRaw[i] = 1'b1;
        SRC_EXT:    reqRaw[i] = extReq[i] && extOk[i];
        SRC_PERIPH: reqRaw[i] = periphReq[i];
        default:    reqRaw[i] = 1'b0;
      endcase
    end

    assign eligible[i] = globalOk && chEnable[i] && !endFlags[i]
                         && chPresent[i] && reqRaw[i];
  end

  // fixed priority, index 0 first
  logic            pickValid;
  logic [ID_W-1:0] pickId;
  always_comb begin
    pickValid = 1'b0;
    pickId    = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (eligible[k]) begin
        pickValid = 1'b1;
        pickId    = ID_W'(k);
      end
    end
  end

  logic finish, release_, keep;
  assign finish   = grantValid && xferDone;
  assign release_ = finish && (lastXfer[grantId] || !burstMode[grantId]);
  assign keep     = eligible[grantId] && !release_;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantId    <= '0;
    end else if (grantValid) begin
      if (!keep) grantValid <= 1'b0;
    end else if (pickValid) begin
      grantValid <= 1'b1;
      grantId    <= pickId;
    end
  end

  always_comb begin
    grantVec = '0;
    if (grantValid) grantVec[grantId] = 1'b1;
  end

  assign strobe.decValid = finish;
  assign strobe.decIdx   = grantId;
endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterEn,
  input  logic              nmiFlag,
  input  logic              addrErrFlag,
  input  logic              altMode,
  input  logic              chCount8,
  input  logic [NUM_CH-1:0]   chEnable,
  input  logic [2*NUM_CH-1:0] srcSel,
  input  logic [NUM_CH-1:0]   burstMode,
  input  logic [NUM_CH-1:0]   extReq,
  input  logic [NUM_CH-1:0]   periphReq,
  input  logic [NUM_CH-1:0]   cntLoad,
  input  logic [CNT_W-1:0]    loadVal,
  input  logic                xferDone,
  output logic                grantValid,
  output logic [ID_W-1:0]     grantId,
  output logic [NUM_CH-1:0]   grantVec,
  output logic [NUM_CH-1:0]   endFlags
);
  ctrlStrobe_t       strobe;
  logic [NUM_CH-1:0] lastXfer;

  dma_arb_ctrl #(.NCH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .nmiFlag(nmiFlag),
    .addrErrFlag(addrErrFlag), .altMode(altMode), .chCount8(chCount8),
    .chEnable(chEnable), .srcSel(srcSel), .burstMode(burstMode),
    .extReq(extReq), .periphReq(periphReq), .endFlags(endFlags),
    .lastXfer(lastXfer), .xferDone(xferDone), .grantValid(grantValid),
    .grantId(grantId), .grantVec(grantVec), .strobe(strobe)
  );

  dma_arb_dp #(.NCH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cntLoad(cntLoad), .loadVal(loadVal),
    .strobe(strobe), .endFlags(endFlags), .lastXfer(lastXfer)
  );
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk
  import dma_arb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              masterEn,
  input logic              nmiFlag,
  input logic              addrErrFlag,
  input logic              altMode,
  input logic              chCount8,
  input logic [NUM_CH-1:0] burstMode,
  input logic              xferDone,
  input logic              grantValid,
  input logic [ID_W-1:0]   grantId,
  input logic [NUM_CH-1:0] grantVec
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && (grantValid == (grantVec != '0)));  // R3

  AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !$past(grantValid)) |-> $past(masterEn && !nmiFlag && !addrErrFlag));  // R1

  AST_MASTER_SUSPEND: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !masterEn) |=> !grantValid);  // R2

  AST_FAULT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && (nmiFlag || addrErrFlag)) |=> !grantValid);  // R10

  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && xferDone && !burstMode[grantId]) |=> !grantValid);  // R8

  AST_ALT_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !$past(grantValid) && $past(altMode) && !$past(chCount8))
      |-> (32'(grantId) < NUM_CH / 2));  // R6
endmodule

bind dma_arb dma_arb_chk u_chk (
  .clk(clk), .rstN(rstN), .masterEn(masterEn), .nmiFlag(nmiFlag),
  .addrErrFlag(addrErrFlag), .altMode(altMode), .chCount8(chCount8),
  .burstMode(burstMode), .xferDone(xferDone), .grantValid(grantValid),
  .grantId(grantId), .grantVec(grantVec)
);

// File: tb/dma_arb_tb.sv
module dma_arb_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterEn, nmiFlag, addrErrFlag, altMode, chCount8, xferDone;
  logic [7:0]  chEnable, burstMode, extReq, periphReq, cntLoad;
  logic [15:0] srcSel, loadVal;
  logic        grantValid;
  logic [2:0]  grantId;
  logic [7:0]  grantVec, endFlags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_arb u_dut (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .nmiFlag(nmiFlag),
    .addrErrFlag(addrErrFlag), .altMode(altMode), .chCount8(chCount8),
    .chEnable(chEnable), .srcSel(srcSel), .burstMode(burstMode),
    .extReq(extReq), .periphReq(periphReq), .cntLoad(cntLoad),
    .loadVal(loadVal), .xferDone(xferDone), .grantValid(grantValid),
    .grantId(grantId), .grantVec(grantVec), .endFlags(endFlags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic checkGrant(input string tag, input bit expValid, input int expId);
    chk({tag, " valid"}, int'(grantValid), int'(expValid));
    if (expValid) begin
      chk({tag, " id"}, int'(grantId), expId);
      chk({tag, " vec"}, int'(grantVec), 1 << expId);
    end else begin
      chk({tag, " vec"}, int'(grantVec), 0);
    end
  endtask

  task automatic setIdle();
    masterEn = 1'b1; nmiFlag = 1'b0; addrErrFlag = 1'b0;
    altMode = 1'b0; chCount8 = 1'b0; chEnable = '0;
    srcSel = 16'hFFFF; burstMode = '0; extReq = '0; periphReq = '0;
    cntLoad = '0; loadVal = '0; xferDone = 1'b0;
  endtask

  task automatic setSrc(input int ch, input logic [1:0] code);
    srcSel[2*ch +: 2] = code;
  endtask

  // reset, then load every counter with 3
  task automatic doReset();
    setIdle();
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
    cntLoad = 8'hFF; loadVal = 16'd3;
    step();
    cntLoad = '0;
  endtask

  task automatic pulseDone();
    xferDone = 1'b1;
    step();
    xferDone = 1'b0;
  endtask

  task automatic testReset();
    setIdle();
    rstN = 1'b0;
    step(); step();
    checkGrant("R11 reset", 1'b0, 0);
    chk("R11 end flags after reset", int'(endFlags), 8'hFF);
    rstN = 1'b1;
    step();
    chk("R11 end flags hold", int'(endFlags), 8'hFF);
    cntLoad = 8'hFF; loadVal = 16'd3;
    step();
    cntLoad = '0;
    chk("R9 load clears end flags", int'(endFlags), 0);
  endtask

  task automatic testGating();
    doReset();
    setSrc(3, 2'd0);
    chEnable[3] = 1'b1; masterEn = 1'b0;
    step(); step();
    checkGrant("R1 master off", 1'b0, 0);
    masterEn = 1'b1; chEnable[3] = 1'b0;
    step(); step();
    checkGrant("R1 channel off", 1'b0, 0);
    chEnable[3] = 1'b1;
    step();
    checkGrant("R12 R1 granted next edge", 1'b1, 3);
  endtask

  task automatic testPriority();
    doReset();
    setSrc(2, 2'd0); setSrc(5, 2'd0); setSrc(6, 2'd0);
    chEnable = 8'b0110_0100;
    step();
    checkGrant("R3 lowest index", 1'b1, 2);
    chEnable[2] = 1'b0;
    step();
    checkGrant("R12 drop on disable", 1'b0, 0);
    step();
    checkGrant("R3 next in order", 1'b1, 5);
  endtask

  task automatic testSources();
    doReset();
    setSrc(0, 2'd3); setSrc(1, 2'd2); setSrc(3, 2'd2);
    chEnable = 8'b0000_1011;
    periphReq[3] = 1'b1;
    step();
    checkGrant("R4 off and idle periph skipped", 1'b1, 3);
    chEnable[3] = 1'b0; periphReq[1] = 1'b1;
    step();
    checkGrant("R4 release", 1'b0, 0);
    step();
    checkGrant("R4 periph request", 1'b1, 1);
  endtask

  task automatic testExtNormal();
    doReset();
    for (int c = 2; c < 8; c++) setSrc(c, 2'd1);
    chEnable = 8'hFF; extReq = 8'hFF;
    step(); step();
    checkGrant("R5 ext ignored on 2..7", 1'b0, 0);
    setSrc(1, 2'd1);
    step();
    checkGrant("R5 ext on channel 1", 1'b1, 1);
  endtask

  task automatic testAlt();
    doReset();
    altMode = 1'b1; chCount8 = 1'b0;
    for (int c = 4; c < 8; c++) setSrc(c, 2'd0);
    chEnable = 8'hF0;
    step(); step();
    checkGrant("R6 upper half absent", 1'b0, 0);
    setSrc(3, 2'd1); chEnable[3] = 1'b1; extReq[3] = 1'b1;
    step();
    checkGrant("R6 ext on channel 3", 1'b1, 3);
    doReset();
    altMode = 1'b1; chCount8 = 1'b1;
    setSrc(6, 2'd1); chEnable[6] = 1'b1; extReq[6] = 1'b1;
    step();
    checkGrant("R6 eight channels ext 6", 1'b1, 6);
  endtask

  task automatic testBurst();
    doReset();
    setSrc(2, 2'd0); setSrc(4, 2'd0);
    chEnable = 8'b0001_0100; burstMode[2] = 1'b1;
    step();
    checkGrant("R7 burst start", 1'b1, 2);
    pulseDone();
    checkGrant("R7 hold after 1", 1'b1, 2);
    pulseDone();
    checkGrant("R7 hold after 2", 1'b1, 2);
    chk("R7 no end yet", int'(endFlags[2]), 0);
    pulseDone();
    checkGrant("R7 released at end", 1'b0, 0);
    chk("R7 end flag set", int'(endFlags[2]), 1);
    step();
    checkGrant("R7 next channel", 1'b1, 4);
  endtask

  task automatic testSteal();
    doReset();
    setSrc(1, 2'd0); setSrc(3, 2'd0);
    chEnable = 8'b0000_1010;
    step();
    checkGrant("R8 start", 1'b1, 1);
    for (int n = 0; n < 2; n++) begin
      pulseDone();
      checkGrant("R8 idle gap", 1'b0, 0);
      step();
      checkGrant("R8 rearbitrate", 1'b1, 1);
    end
    pulseDone();
    chk("R8 end flag", int'(endFlags[1]), 1);
    step();
    checkGrant("R8 lower channel", 1'b1, 3);
  endtask

  task automatic testSuspend();
    doReset();
    setSrc(0, 2'd0); chEnable[0] = 1'b1; burstMode[0] = 1'b1;
    step();
    checkGrant("R2 start", 1'b1, 0);
    pulseDone();
    masterEn = 1'b0;
    step();
    checkGrant("R2 suspended", 1'b0, 0);
    step();
    checkGrant("R2 stays off", 1'b0, 0);
    masterEn = 1'b1;
    step();
    checkGrant("R2 resume", 1'b1, 0);
    pulseDone();
    checkGrant("R2 count kept", 1'b1, 0);
    pulseDone();
    checkGrant("R2 ends after remaining", 1'b0, 0);
    chk("R2 end flag", int'(endFlags[0]), 1);
  endtask

  task automatic testFault();
    doReset();
    setSrc(0, 2'd0); chEnable[0] = 1'b1;
    step();
    checkGrant("R10 start", 1'b1, 0);
    nmiFlag = 1'b1;
    step();
    checkGrant("R10 nmi drop", 1'b0, 0);
    step();
    checkGrant("R10 nmi blocks", 1'b0, 0);
    nmiFlag = 1'b0;
    step();
    checkGrant("R10 regrant", 1'b1, 0);
    addrErrFlag = 1'b1;
    step();
    checkGrant("R10 addr err drop", 1'b0, 0);
    addrErrFlag = 1'b0;
    step();
    checkGrant("R10 regrant after ae", 1'b1, 0);
  endtask

  task automatic testZeroLoad();
    doReset();
    loadVal = 16'd0; cntLoad[5] = 1'b1;
    step();
    cntLoad = '0;
    chk("R9 zero load sets end", int'(endFlags), 8'h20);
    setSrc(5, 2'd0); chEnable[5] = 1'b1;
    step(); step();
    checkGrant("R1 end flag blocks", 1'b0, 0);
    loadVal = 16'd2; cntLoad[5] = 1'b1;
    step();
    cntLoad = '0;
    chk("R9 reload clears", int'(endFlags), 0);
    checkGrant("R9 not yet", 1'b0, 0);
    step();
    checkGrant("R9 granted after reload", 1'b1, 5);
  endtask

  initial begin
    setIdle();
    testReset();
    testGating();
    testPriority();
    testSources();
    testExtNormal();
    testAlt();
    testBurst();
    testSteal();
    testSuspend();
    testFault();
    testZeroLoad();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule